// File: doc/BRIEF.md
# Coprocessor trap control register

This block holds the hypervisor's trap settings for floating-point, SIMD and coprocessor-access-control work done by less privileged non-secure software. It is a 32-bit register with four writable trap bits and fixed reserved bits. Software reads and writes it through an access port. The port honours the access only from hypervisor mode, or from monitor mode while the non-secure flag is set. Any other access is refused and flagged as undefined.

Several trap bits can be pinned so that they read as one and ignore writes. One source is the implementation straps that say whether floating-point and SIMD hardware exist. The other source is the secure side's disable inputs, which act only on the non-secure view of the register. The same effective bits drive four trap-decision outputs. Each output answers a request from non-secure user or kernel code in the same cycle as the request. Setting both coprocessor trap bits also traps all SIMD use.

Top module: `cptrap_reg`

## Requirements
- R1: After reset, the four writable trap bits are 0. A hypervisor read with both straps present and no secure disables returns 0x000033FF, and no trap output is asserted.
- R2: The writable bits sit at positions 31 (control-register trap), 15 (SIMD trap), 11 (coprocessor 11 trap) and 10 (coprocessor 10 trap). A permitted write stores them, and the stored value is visible from the next cycle. Bits 30:16 and 14 always read 0. Bits 13:12 and 9:0 always read 1. Writes to all of these reserved bits are ignored.
- R3: An access is permitted when mode = 2'b10 (hypervisor), or when mode = 2'b11 (monitor) with the non-secure flag at 1. Modes 2'b00 and 2'b01 are user and kernel. A refused access raises acc_undef in the same cycle, returns 0 on acc_rdata and leaves the stored bits unchanged. A permitted access returns the current effective value in the same cycle.
- R4: While simd_present is 0, bit 15 reads as 1, traps as set, and a write to it is ignored. The stored bit shows again once the strap returns to 1.
- R5: While both fp_present and simd_present are 0, bits 11 and 10 read as 1, trap as set, and writes to them are ignored.
- R6: A secure disable input (SIMD, coprocessor 10, coprocessor 11) forces the matching bit to 1 in the non-secure view. That view is what hypervisor accesses and trap decisions use. Hypervisor writes to a forced bit are ignored. A monitor access sees and writes the stored bit.
- R7: Trap outputs are asserted only when cur_ns is 1 and the mode is user or kernel. They respond combinationally, in the same cycle as the matching request input.
- R8: A SIMD request traps when bit 15 is effectively set, or when bits 11 and 10 are both effectively set.
- R9: Requests for the control register, coprocessor 10 and coprocessor 11 trap exactly when bits 31, 10 and 11 respectively are effectively set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_mode | input | 2 | Current mode: 00 user, 01 kernel, 10 hypervisor, 11 monitor |
| cur_ns | input | 1 | Current non-secure flag |
| acc_req | input | 1 | Register access request |
| acc_wr | input | 1 | Access is a write |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Effective read value, 0 if refused or idle |
| acc_undef | output | 1 | Access refused |
| fp_present | input | 1 | Strap: floating-point implemented |
| simd_present | input | 1 | Strap: SIMD implemented |
| sec_dis_simd | input | 1 | Secure side prohibits non-secure SIMD |
| sec_dis_cp10 | input | 1 | Secure side prohibits non-secure coprocessor 10 |
| sec_dis_cp11 | input | 1 | Secure side prohibits non-secure coprocessor 11 |
| use_acr | input | 1 | Request: access to the coprocessor access control register |
| use_simd | input | 1 | Request: SIMD use |
| use_cp10 | input | 1 | Request: coprocessor 10 use |
| use_cp11 | input | 1 | Request: coprocessor 11 use |
| trap_acr | output | 1 | Trap decision for the access-control request |
| trap_simd | output | 1 | Trap decision for SIMD use |
| trap_cp10 | output | 1 | Trap decision for coprocessor 10 |
| trap_cp11 | output | 1 | Trap decision for coprocessor 11 |

## Verification
The bench writes all-ones and all-zeros to show that stored bits and reserved bits are handled separately. It then writes each coprocessor bit alone and both together, which separates the plain SIMD trap from the override by the coprocessor pair. Requests are issued from every mode and security combination, so lower-level non-secure traps can be told apart from silenced ones. Each strap and secure disable is toggled around writes, which shows whether a forced bit truly ignored the write or only masked it on read. It also shows that monitor accesses see the stored bit rather than the forced one.

// File: rtl/cptrap_pkg.sv
package cptrap_pkg;
   typedef enum logic [1:0] {
      PM_USR = 2'b00,
      PM_KRN = 2'b01,
      PM_HYP = 2'b10,
      PM_MON = 2'b11
   } pmode_e;

   localparam int unsigned NTRAP   = 4;
   localparam int unsigned TI_ACR  = 0;
   localparam int unsigned TI_SIMD = 1;
   localparam int unsigned TI_CP10 = 2;
   localparam int unsigned TI_CP11 = 3;
endpackage

// File: rtl/cptrap_gate.sv
module cptrap_gate
   import cptrap_pkg::*;
(
   input  logic       req,
   input  logic       wr,
   input  logic [1:0] mode,
   input  logic       ns,
   output logic       rd_ok,
   output logic       wr_ok,
   output logic       undef,
   output logic       ns_view,
   output logic       lower_ns
);
   logic allowed;

   always_comb begin
      allowed  = (mode == PM_HYP) || ((mode == PM_MON) && ns);
      rd_ok    = req && allowed;
      wr_ok    = req && allowed && wr;
      undef    = req && !allowed;
      // hypervisor code is always non-secure; monitor sees the stored copy
      ns_view  = (mode == PM_HYP);
      lower_ns = ns && ((mode == PM_USR) || (mode == PM_KRN));
   end
endmodule

// File: rtl/cptrap_fieldbit.sv
module cptrap_fieldbit (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wdata_bit,
   input  logic force_strap,
   input  logic force_sec,
   input  logic ns_view,
   output logic rd_bit,
   output logic trap_bit,
   output logic stored_q
);
   logic pinned_now;

   always_comb begin
      pinned_now = force_strap || (force_sec && ns_view);
      rd_bit     = stored_q || pinned_now;
      trap_bit   = stored_q || force_strap || force_sec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   stored_q <= 1'b0;
      else if (wr_en && !pinned_now) stored_q <= wdata_bit;
   end

   // R2: an unpinned write lands on the next cycle
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !pinned_now) |=> (stored_q == $past(wdata_bit)));
   // R4/R5/R6: a pinned write leaves the stored bit alone
   a_r4_pinned_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && pinned_now) |=> $stable(stored_q));
endmodule

// File: rtl/cptrap_decide.sv
module cptrap_decide
   import cptrap_pkg::*;
(
   input  logic             lower_ns,
   input  logic [NTRAP-1:0] use_req,
   input  logic [NTRAP-1:0] eff,
   output logic [NTRAP-1:0] trap
);
   for (genvar i = 0; i < NTRAP; i++) begin : g_cls
      if (i == TI_SIMD) begin : g_simd
         assign trap[i] = lower_ns && use_req[i] &&
                          (eff[i] || (eff[TI_CP10] && eff[TI_CP11]));
      end else begin : g_plain
         assign trap[i] = lower_ns && use_req[i] && eff[i];
      end
   end
endmodule

// File: rtl/cptrap_reg.sv
module cptrap_reg
   import cptrap_pkg::*;
#(
   parameter int unsigned           DATA_W    = 32,
   parameter int unsigned           POS_ACR   = 31,
   parameter int unsigned           POS_SIMD  = 15,
   parameter int unsigned           POS_CP11  = 11,
   parameter int unsigned           POS_CP10  = 10,
   parameter logic [DATA_W-1:0]     ONES_MASK = 32'h0000_33FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cur_mode,
   input  logic              cur_ns,
   input  logic              acc_req,
   input  logic              acc_wr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              acc_undef,
   input  logic              fp_present,
   input  logic              simd_present,
   input  logic              sec_dis_simd,
   input  logic              sec_dis_cp10,
   input  logic              sec_dis_cp11,
   input  logic              use_acr,
   input  logic              use_simd,
   input  logic              use_cp10,
   input  logic              use_cp11,
   output logic              trap_acr,
   output logic              trap_simd,
   output logic              trap_cp10,
   output logic              trap_cp11
);
   localparam int unsigned POS_W = $clog2(DATA_W);

   function automatic int unsigned pos_of(int unsigned idx);
      case (idx)
         TI_ACR:  return POS_ACR;
         TI_SIMD: return POS_SIMD;
         TI_CP10: return POS_CP10;
         default: return POS_CP11;
      endcase
   endfunction

   if (POS_ACR >= DATA_W || POS_SIMD >= DATA_W || POS_CP10 >= DATA_W || POS_CP11 >= DATA_W)
   begin : g_bad_pos
      $error("cptrap_reg: trap bit position outside register");
   end
   if (POS_W < 1) begin : g_bad_w
      $error("cptrap_reg: register too narrow");
   end

   logic rd_ok, wr_ok, ns_view, lower_ns;

   cptrap_gate i_gate (
      .req      (acc_req),
      .wr       (acc_wr),
      .mode     (cur_mode),
      .ns       (cur_ns),
      .rd_ok    (rd_ok),
      .wr_ok    (wr_ok),
      .undef    (acc_undef),
      .ns_view  (ns_view),
      .lower_ns (lower_ns)
   );

   logic [NTRAP-1:0] f_strap, f_sec, rd_bits, trap_bits, stored, use_req, trap_vec;
   logic             no_fpu;

   assign no_fpu = !fp_present && !simd_present;

   always_comb begin
      f_strap          = '0;
      f_strap[TI_SIMD] = !simd_present;
      f_strap[TI_CP10] = no_fpu;
      f_strap[TI_CP11] = no_fpu;
      f_sec            = '0;
      f_sec[TI_SIMD]   = sec_dis_simd;
      f_sec[TI_CP10]   = sec_dis_cp10;
      f_sec[TI_CP11]   = sec_dis_cp11;
   end

   for (genvar i = 0; i < NTRAP; i++) begin : g_bit
      cptrap_fieldbit i_fb (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_en       (wr_ok),
         .wdata_bit   (acc_wdata[pos_of(i)]),
         .force_strap (f_strap[i]),
         .force_sec   (f_sec[i]),
         .ns_view     (ns_view),
         .rd_bit      (rd_bits[i]),
         .trap_bit    (trap_bits[i]),
         .stored_q    (stored[i])
      );
   end

   logic [DATA_W-1:0] word;
   always_comb begin
      word = ONES_MASK;
      for (int i = 0; i < NTRAP; i++) word[pos_of(i)] = rd_bits[i];
   end
   assign acc_rdata = rd_ok ? word : '0;

   assign use_req = {use_cp11, use_cp10, use_simd, use_acr};

   cptrap_decide i_dec (
      .lower_ns (lower_ns),
      .use_req  (use_req),
      .eff      (trap_bits),
      .trap     (trap_vec)
   );

   assign trap_acr  = trap_vec[TI_ACR];
   assign trap_simd = trap_vec[TI_SIMD];
   assign trap_cp10 = trap_vec[TI_CP10];
   assign trap_cp11 = trap_vec[TI_CP11];

   // R3: refused access keeps state and returns zero
   a_r3_refused_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      acc_undef |=> $stable(stored));
   a_r3_refused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      acc_undef |-> (acc_rdata == '0));
   // R7: nothing traps outside non-secure user/kernel
   a_r7_quiet_outside_lower: assert property (@(posedge clk) disable iff (!rst_n)
      !(cur_ns && (cur_mode == PM_USR || cur_mode == PM_KRN)) |-> (trap_vec == '0));
   // R8: coprocessor pair forces SIMD trap
   a_r8_pair_forces_simd: assert property (@(posedge clk) disable iff (!rst_n)
      (lower_ns && use_simd && trap_bits[TI_CP10] && trap_bits[TI_CP11]) |-> trap_simd);
endmodule

// File: tb/test_cptrap_reg.sv
module test_cptrap_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cur_mode = 2'b00;
   logic        cur_ns = 1'b0;
   logic        acc_req = 1'b0, acc_wr = 1'b0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        acc_undef;
   logic        fp_present = 1'b1, simd_present = 1'b1;
   logic        sec_dis_simd = 1'b0, sec_dis_cp10 = 1'b0, sec_dis_cp11 = 1'b0;
   logic        use_acr = 1'b0, use_simd = 1'b0, use_cp10 = 1'b0, use_cp11 = 1'b0;
   logic        trap_acr, trap_simd, trap_cp10, trap_cp11;

   always #4 clk = ~clk;   // 125 MHz

   cptrap_reg i_cptrap_reg (.*);

   typedef struct {
      int          sel;   // 0 rdata, 1 undef, 2 traps {cp11,cp10,simd,acr}
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t q[$];
   int n_run = 0, n_fail = 0;
   bit done = 0;

   localparam logic [1:0] USR = 2'b00, KRN = 2'b01, HYP = 2'b10, MON = 2'b11;

   // monitor: compare each queued item away from the clock edge
   initial forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = q.pop_front();
         case (it.sel)
            0: act = acc_rdata;
            1: act = {31'b0, acc_undef};
            default: act = {28'b0, trap_cp11, trap_cp10, trap_simd, trap_acr};
         endcase
         n_run++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
         end
      end
   end

   task automatic idle_inputs();
      acc_req = 0; acc_wr = 0;
      {use_cp11, use_cp10, use_simd, use_acr} = 4'b0;
   endtask

   task automatic acc(input logic [1:0] m, input logic ns, input logic wr,
                      input logic [31:0] wd, input logic [31:0] erd,
                      input logic eun, input string tag);
      @(negedge clk);
      idle_inputs();
      cur_mode = m; cur_ns = ns; acc_req = 1; acc_wr = wr; acc_wdata = wd;
      q.push_back('{0, erd, tag});
      q.push_back('{1, {31'b0, eun}, tag});
   endtask

   task automatic rd(input logic [31:0] e, input string tag);
      acc(HYP, 1, 0, '0, e, 0, tag);
   endtask

   task automatic trp(input logic [1:0] m, input logic ns, input logic [3:0] r,
                      input logic [3:0] e, input string tag);
      @(negedge clk);
      idle_inputs();
      cur_mode = m; cur_ns = ns;
      {use_cp11, use_cp10, use_simd, use_acr} = r;
      q.push_back('{2, {28'b0, e}, tag});
   endtask

   task automatic cfg(input logic fp, input logic sm, input logic ds,
                      input logic d10, input logic d11);
      @(negedge clk);
      idle_inputs();
      fp_present = fp; simd_present = sm;
      sec_dis_simd = ds; sec_dis_cp10 = d10; sec_dis_cp11 = d11;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(32'h0000_33FF, "R1 reset read");
      trp(KRN, 1, 4'b1111, 4'b0000, "R1 no trap after reset");
      // R2 write all ones, reserved bits hold
      acc(HYP, 1, 1, 32'hFFFF_FFFF, 32'h0000_33FF, 0, "R2 write cycle shows old");
      rd(32'h8000_BFFF, "R2 readback all ones");
      // R9 / R7 traps
      trp(KRN, 1, 4'b1111, 4'b1111, "R9 kernel ns all trap");
      trp(USR, 1, 4'b1111, 4'b1111, "R7 user ns all trap");
      trp(KRN, 0, 4'b1111, 4'b0000, "R7 secure kernel quiet");
      trp(HYP, 1, 4'b1111, 4'b0000, "R7 hyp quiet");
      trp(MON, 1, 4'b1111, 4'b0000, "R7 monitor quiet");
      // R3 permission
      acc(MON, 1, 1, 32'h0000_0000, 32'h8000_BFFF, 0, "R3 monitor ns write ok");
      rd(32'h0000_33FF, "R3 monitor write landed");
      acc(MON, 0, 1, 32'hFFFF_FFFF, 32'h0, 1, "R3 secure monitor refused");
      rd(32'h0000_33FF, "R3 refused write kept state");
      acc(KRN, 1, 1, 32'hFFFF_FFFF, 32'h0, 1, "R3 kernel refused");
      acc(USR, 1, 0, 32'h0, 32'h0, 1, "R3 user read refused");
      rd(32'h0000_33FF, "R3 state unchanged");
      // R8 pair override
      acc(HYP, 1, 1, 32'h0000_0C00, 32'h0000_33FF, 0, "R2 write pair");
      rd(32'h0000_3FFF, "R2 pair readback");
      trp(KRN, 1, 4'b0010, 4'b0010, "R8 pair forces simd trap");
      trp(KRN, 1, 4'b1111, 4'b1110, "R9 acr clear not trapped");
      acc(HYP, 1, 1, 32'h0000_0400, 32'h0000_3FFF, 0, "R2 write cp10 only");
      rd(32'h0000_37FF, "R2 cp10 readback");
      trp(KRN, 1, 4'b0010, 4'b0000, "R8 single cp bit no simd trap");
      trp(USR, 1, 4'b1100, 4'b0100, "R9 cp10 only");
      // R6 secure SIMD disable
      cfg(1, 1, 1, 0, 0);
      rd(32'h0000_B7FF, "R6 hyp sees forced simd");
      acc(MON, 1, 0, 32'h0, 32'h0000_37FF, 0, "R6 monitor sees stored");
      trp(KRN, 1, 4'b0010, 4'b0010, "R6 forced simd traps");
      acc(MON, 1, 1, 32'h0000_8000, 32'h0000_37FF, 0, "R6 monitor writes simd");
      acc(MON, 1, 0, 32'h0, 32'h0000_B3FF, 0, "R6 monitor readback");
      acc(HYP, 1, 1, 32'h0000_0000, 32'h0000_B3FF, 0, "R6 hyp write under force");
      cfg(1, 1, 0, 0, 0);
      rd(32'h0000_B3FF, "R6 forced bit ignored hyp write");
      acc(HYP, 1, 1, 32'h0000_0000, 32'h0000_B3FF, 0, "R2 clear");
      rd(32'h0000_33FF, "R2 cleared");
      cfg(1, 1, 0, 1, 0);
      rd(32'h0000_37FF, "R6 cp10 disable forces bit");
      trp(USR, 1, 4'b0100, 4'b0100, "R6 cp10 forced trap");
      cfg(1, 1, 0, 1, 1);
      rd(32'h0000_3FFF, "R6 both cp disables");
      trp(KRN, 1, 4'b0010, 4'b0010, "R8 forced pair traps simd");
      cfg(1, 1, 0, 0, 0);
      rd(32'h0000_33FF, "R6 release restores");
      // R4 SIMD strap absent
      cfg(1, 0, 0, 0, 0);
      rd(32'h0000_B3FF, "R4 simd absent reads one");
      trp(KRN, 1, 4'b0010, 4'b0010, "R4 simd absent traps");
      acc(MON, 1, 1, 32'h0000_8000, 32'h0000_B3FF, 0, "R4 write under strap");
      cfg(1, 1, 0, 0, 0);
      rd(32'h0000_33FF, "R4 strap write ignored");
      // R5 no floating point at all
      cfg(0, 0, 0, 0, 0);
      rd(32'h0000_BFFF, "R5 no fp pins bits");
      trp(USR, 1, 4'b1100, 4'b1100, "R5 cp traps forced");
      acc(HYP, 1, 1, 32'h0000_0C00, 32'h0000_BFFF, 0, "R5 write under strap");
      cfg(1, 1, 0, 0, 0);
      rd(32'h0000_33FF, "R5 strap write ignored");
      @(negedge clk);
      idle_inputs();
      repeat (2) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule